// File: doc/BRIEF.md
# Clear-on-read alarm transition interrupt controller

This block gathers the per-channel alarm flags of an eight-channel line interface into one interrupt line. There are two alarm groups: loss of signal (LOS) and alarm indication signal (AIS). Each group has three registers of one bit per channel. The live register mirrors the synchronized alarm input. The mask register is writable by the host. The pending register holds sticky event bits. A pending bit is set when the live value of an unmasked channel changes, whether the flag rises or falls.

The host reaches the registers over a small parallel bus with an address, an active-low read strobe, an active-low write strobe, write data and read data. When the host reads a group's pending register or its live register, all pending bits of that group are cleared. The clear happens when the read strobe is released, so the value returned is the one from before the clear. A single interrupt line is pulled low while any pending bit is set. It is released only when both groups are empty. The line can be configured as an open-drain pull-down, so several devices can share one wired line.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: Reading the live register of a group (LOS at 0x04, AIS at 0x13) returns the synchronized alarm inputs, bit n for channel n. It follows the inputs whatever the mask bits are.
- R2: The mask registers sit at 0x06 (LOS) and 0x14 (AIS). The pending registers sit at 0x08 (LOS) and 0x15 (AIS). A value written to a mask register reads back unchanged.
- R3: A change of a live bit in either direction on an unmasked channel sets that channel's pending bit. The bit stays set until a clearing read.
- R4: A change on a channel whose mask bit is 0 sets no pending bit. Both mask registers reset to 0.
- R5: Reading a pending register returns its current contents. All pending bits of that group are cleared when the read strobe goes back high.
- R6: The interrupt line is low while any pending bit of either group is set. It is high once all pending bits are clear.
- R7: Reading a group's live register also clears that group's pending bits. The other group is left untouched.
- R8: If a channel changes in the same cycle that a clearing read of its group completes, its pending bit stays set.
- R9: In open-drain mode the output never drives high. The drive enable is active exactly while the line is pulled low, and the driven value is 0.
- R10: Reads of unmapped addresses return 0 and clear nothing. Writes to live or pending registers change nothing.
- R11: After reset all registers read 0 and the interrupt line is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| los_in | input | NUM_CH | Live loss-of-signal flags, one per channel |
| ais_in | input | NUM_CH | Live alarm-indication flags, one per channel |
| addr | input | ADDR_W | Host register address |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| wdata | input | NUM_CH | Host write data |
| rdata | output | NUM_CH | Host read data, 0 while rd_n is high |
| irq_n | output | 1 | Interrupt drive value (0 in open-drain mode) |
| irq_oe | output | 1 | Interrupt drive enable |

## Verification
The properties assume that both strobes are synchronous to the clock, are held low for at least one full cycle, and are never low together. They also assume the address is stable for the whole time the read strobe is low. The alarm inputs may change at any cycle. The stimulus drives every input on the falling clock edge and keeps each strobe low for a whole cycle. Every read is issued as one complete strobe with a fixed address. The colliding read is timed so that its release lands in the same cycle as the detected alarm change.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;

   localparam logic [7:0] ADR_LOS_LIVE = 8'h04;
   localparam logic [7:0] ADR_LOS_MASK = 8'h06;
   localparam logic [7:0] ADR_LOS_PEND = 8'h08;
   localparam logic [7:0] ADR_AIS_LIVE = 8'h13;
   localparam logic [7:0] ADR_AIS_MASK = 8'h14;
   localparam logic [7:0] ADR_AIS_PEND = 8'h15;

   localparam int unsigned NUM_GROUPS = 2;

   typedef enum logic [2:0] {
      SEL_NONE     = 3'd0,
      SEL_LOS_LIVE = 3'd1,
      SEL_LOS_MASK = 3'd2,
      SEL_LOS_PEND = 3'd3,
      SEL_AIS_LIVE = 3'd4,
      SEL_AIS_MASK = 3'd5,
      SEL_AIS_PEND = 3'd6
   } reg_sel_e;

   function automatic reg_sel_e decode_addr(input logic [7:0] a, input logic hi_zero);
      reg_sel_e s;
      s = SEL_NONE;
      if (hi_zero) begin
         case (a)
            ADR_LOS_LIVE: s = SEL_LOS_LIVE;
            ADR_LOS_MASK: s = SEL_LOS_MASK;
            ADR_LOS_PEND: s = SEL_LOS_PEND;
            ADR_AIS_LIVE: s = SEL_AIS_LIVE;
            ADR_AIS_MASK: s = SEL_AIS_MASK;
            ADR_AIS_PEND: s = SEL_AIS_PEND;
            default:      s = SEL_NONE;
         endcase
      end
      return s;
   endfunction

endpackage

// File: rtl/alarm_sync.sv
module alarm_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   localparam int unsigned LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("alarm_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("alarm_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= '0;
      else        stage_q[0] <= async_i;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   endgenerate

   assign sync_o = stage_q[LAST];

endmodule

// File: rtl/alarm_group.sv
module alarm_group #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] live_i,
   input  logic             mask_we_i,
   input  logic [WIDTH-1:0] wdata_i,
   input  logic             clear_i,
   output logic [WIDTH-1:0] live_q_o,
   output logic [WIDTH-1:0] mask_o,
   output logic [WIDTH-1:0] pend_o,
   output logic [WIDTH-1:0] change_o
);

   logic [WIDTH-1:0] live_q;
   logic [WIDTH-1:0] mask_q;
   logic [WIDTH-1:0] pend_q;
   logic [WIDTH-1:0] hit;
   logic [WIDTH-1:0] keep;

   // Any difference between the newest synchronized sample and the held
   // live value is a transition, whichever direction it goes.
   assign change_o = live_i ^ live_q;
   assign hit      = change_o & mask_q;
   assign keep     = clear_i ? '0 : pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= '0;
      else        live_q <= live_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         mask_q <= '0;
      else if (mask_we_i) mask_q <= wdata_i;
   end

   // A fresh event is ORed in after the clear, so it survives a clear
   // that arrives in the same cycle.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= keep | hit;
   end

   assign live_q_o = live_q;
   assign mask_o   = mask_q;
   assign pend_o   = pend_q;

endmodule

// File: rtl/host_regif.sv
module host_regif
   import alarm_irq_pkg::*;
#(
   parameter int unsigned NUM_CH = 8,
   parameter int unsigned ADDR_W = 8
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic [ADDR_W-1:0]                     addr_i,
   input  logic                                  rd_n_i,
   input  logic                                  wr_n_i,
   input  logic [NUM_CH-1:0]                     wdata_i,
   input  logic [NUM_GROUPS-1:0][NUM_CH-1:0]     live_i,
   input  logic [NUM_GROUPS-1:0][NUM_CH-1:0]     mask_i,
   input  logic [NUM_GROUPS-1:0][NUM_CH-1:0]     pend_i,
   output logic [NUM_CH-1:0]                     rdata_o,
   output logic [NUM_GROUPS-1:0]                 mask_we_o,
   output logic [NUM_GROUPS-1:0]                 clear_o
);

   localparam int unsigned HI_SHIFT = 8;

   logic [7:0] addr8;
   logic       hi_zero;
   reg_sel_e   sel_now;
   reg_sel_e   sel_q;
   logic       rd_q;
   logic       rd_release;
   logic [NUM_CH-1:0] mux_out;

   generate
      if (ADDR_W >= 8) begin : g_wide
         assign addr8   = addr_i[7:0];
         assign hi_zero = ((addr_i >> HI_SHIFT) == '0);
      end else begin : g_narrow
         assign addr8   = 8'(addr_i);
         assign hi_zero = 1'b1;
      end
   endgenerate

   assign sel_now = decode_addr(addr8, hi_zero);

   // Remember the target of the read in progress, so that the clear can be
   // applied when the strobe is released.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sel_q <= SEL_NONE;
      else if (!rd_n_i) sel_q <= sel_now;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q <= 1'b1;
      else        rd_q <= rd_n_i;
   end

   assign rd_release = rd_n_i & ~rd_q;

   assign clear_o[0] = rd_release &
                       ((sel_q == SEL_LOS_LIVE) || (sel_q == SEL_LOS_PEND));
   assign clear_o[1] = rd_release &
                       ((sel_q == SEL_AIS_LIVE) || (sel_q == SEL_AIS_PEND));

   assign mask_we_o[0] = !wr_n_i && (sel_now == SEL_LOS_MASK);
   assign mask_we_o[1] = !wr_n_i && (sel_now == SEL_AIS_MASK);

   always_comb begin
      case (sel_now)
         SEL_LOS_LIVE: mux_out = live_i[0];
         SEL_LOS_MASK: mux_out = mask_i[0];
         SEL_LOS_PEND: mux_out = pend_i[0];
         SEL_AIS_LIVE: mux_out = live_i[1];
         SEL_AIS_MASK: mux_out = mask_i[1];
         SEL_AIS_PEND: mux_out = pend_i[1];
         default:      mux_out = '0;
      endcase
   end

   assign rdata_o = rd_n_i ? '0 : mux_out;

endmodule

// File: rtl/irq_out.sv
module irq_out #(
   parameter bit OPEN_DRAIN = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pending_i,
   output logic irq_n_o,
   output logic irq_oe_o
);

   logic active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_q <= 1'b0;
      else        active_q <= pending_i;
   end

   generate
      if (OPEN_DRAIN) begin : g_od
         assign irq_n_o  = 1'b0;
         assign irq_oe_o = active_q;
      end else begin : g_pp
         assign irq_n_o  = ~active_q;
         assign irq_oe_o = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
   import alarm_irq_pkg::*;
#(
   parameter int unsigned NUM_CH      = 8,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          OPEN_DRAIN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] los_in,
   input  logic [NUM_CH-1:0] ais_in,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic [NUM_CH-1:0] wdata,
   output logic [NUM_CH-1:0] rdata,
   output logic              irq_n,
   output logic              irq_oe
);

   generate
      if (NUM_CH < 1 || NUM_CH > 8) begin : g_bad_ch
         $error("alarm_irq_ctrl: NUM_CH must be 1 to 8");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("alarm_irq_ctrl: ADDR_W must reach address 0x15");
      end
   endgenerate

   logic [NUM_GROUPS-1:0][NUM_CH-1:0] live_raw;
   logic [NUM_GROUPS-1:0][NUM_CH-1:0] live_sync;
   logic [NUM_GROUPS-1:0][NUM_CH-1:0] grp_live;
   logic [NUM_GROUPS-1:0][NUM_CH-1:0] grp_mask;
   logic [NUM_GROUPS-1:0][NUM_CH-1:0] grp_pend;
   logic [NUM_GROUPS-1:0][NUM_CH-1:0] grp_change;
   logic [NUM_GROUPS-1:0]             grp_we;
   logic [NUM_GROUPS-1:0]             grp_clr;
   logic                              any_pend;

   assign live_raw[0] = los_in;
   assign live_raw[1] = ais_in;

   generate
      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
         alarm_sync #(
            .WIDTH  (NUM_CH),
            .STAGES (SYNC_STAGES)
         ) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (live_raw[g]),
            .sync_o  (live_sync[g])
         );

         alarm_group #(
            .WIDTH (NUM_CH)
         ) u_grp (
            .clk       (clk),
            .rst_n     (rst_n),
            .live_i    (live_sync[g]),
            .mask_we_i (grp_we[g]),
            .wdata_i   (wdata),
            .clear_i   (grp_clr[g]),
            .live_q_o  (grp_live[g]),
            .mask_o    (grp_mask[g]),
            .pend_o    (grp_pend[g]),
            .change_o  (grp_change[g])
         );
      end
   endgenerate

   host_regif #(
      .NUM_CH (NUM_CH),
      .ADDR_W (ADDR_W)
   ) u_regif (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_i    (addr),
      .rd_n_i    (rd_n),
      .wr_n_i    (wr_n),
      .wdata_i   (wdata),
      .live_i    (grp_live),
      .mask_i    (grp_mask),
      .pend_i    (grp_pend),
      .rdata_o   (rdata),
      .mask_we_o (grp_we),
      .clear_o   (grp_clr)
   );

   assign any_pend = |grp_pend;

   irq_out #(
      .OPEN_DRAIN (OPEN_DRAIN)
   ) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .pending_i (any_pend),
      .irq_n_o   (irq_n),
      .irq_oe_o  (irq_oe)
   );

endmodule

// File: rtl/alarm_irq_chk.sv
module alarm_irq_chk
   import alarm_irq_pkg::*;
#(
   parameter int unsigned NUM_CH     = 8,
   parameter int unsigned ADDR_W     = 8,
   parameter bit          OPEN_DRAIN = 1'b1
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic [ADDR_W-1:0]                 addr,
   input logic                              rd_n,
   input logic [NUM_CH-1:0]                 rdata,
   input logic                              irq_n,
   input logic                              irq_oe,
   input logic [NUM_GROUPS-1:0][NUM_CH-1:0] mask,
   input logic [NUM_GROUPS-1:0][NUM_CH-1:0] pend,
   input logic [NUM_GROUPS-1:0][NUM_CH-1:0] change,
   input logic [NUM_GROUPS-1:0]             clr
);

   logic wire_level;
   logic mapped;

   assign wire_level = irq_oe ? irq_n : 1'b1;
   assign mapped = (addr == ADDR_W'(ADR_LOS_LIVE)) || (addr == ADDR_W'(ADR_LOS_MASK)) ||
                   (addr == ADDR_W'(ADR_LOS_PEND)) || (addr == ADDR_W'(ADR_AIS_LIVE)) ||
                   (addr == ADDR_W'(ADR_AIS_MASK)) || (addr == ADDR_W'(ADR_AIS_PEND));

   generate
      for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_prop
         // R3: a pending bit survives every cycle without a clear
         p_pend_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
            !clr[g] |=> ((pend[g] & $past(pend[g])) == $past(pend[g])));

         // R4: new pending bits appear only on unmasked channels
         p_mask_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((pend[g] & ~$past(pend[g]) & ~$past(mask[g])) == '0));

         // R5: a clear with no simultaneous event empties the group
         p_clear_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[g] && ((change[g] & mask[g]) == '0)) |=> (pend[g] == '0));

         // R8: an unmasked change always lands, even during a clear
         p_event_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            ((change[g] & mask[g]) != '0) |=>
               ((pend[g] & $past(change[g] & mask[g])) == $past(change[g] & mask[g])));
      end

      if (OPEN_DRAIN) begin : g_od_prop
         // R9: the enabled drive is always a low
         p_never_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
            irq_oe |-> !irq_n);
      end
   endgenerate

   // R6: the line level follows the pending contents one cycle later
   p_line_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (wire_level == !(|$past(pend))));

   // R10: unmapped reads return zero
   p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n && !mapped) |-> (rdata == '0));

endmodule

bind alarm_irq_ctrl alarm_irq_chk #(
   .NUM_CH     (NUM_CH),
   .ADDR_W     (ADDR_W),
   .OPEN_DRAIN (OPEN_DRAIN)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .addr   (addr),
   .rd_n   (rd_n),
   .rdata  (rdata),
   .irq_n  (irq_n),
   .irq_oe (irq_oe),
   .mask   (grp_mask),
   .pend   (grp_pend),
   .change (grp_change),
   .clr    (grp_clr)
);

// File: tb/sim_alarm_irq_ctrl.sv
`timescale 1ns/1ps
module sim_alarm_irq_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] los_in = '0;
   logic [7:0] ais_in = '0;
   logic [7:0] addr = '0;
   logic       rd_n = 1'b1;
   logic       wr_n = 1'b1;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq_n;
   logic       irq_oe;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   alarm_irq_ctrl u0 (
      .clk    (clk),
      .rst_n  (rst_n),
      .los_in (los_in),
      .ais_in (ais_in),
      .addr   (addr),
      .rd_n   (rd_n),
      .wr_n   (wr_n),
      .wdata  (wdata),
      .rdata  (rdata),
      .irq_n  (irq_n),
      .irq_oe (irq_oe)
   );

   function automatic logic line_level();
      return irq_oe ? irq_n : 1'b1;
   endfunction

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic host_rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a;
      rd_n = 1'b0;
      @(negedge clk);
      d = rdata;
      rd_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic host_wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      addr  = a;
      wdata = d;
      wr_n  = 1'b0;
      @(negedge clk);
      wr_n = 1'b1;
   endtask

   task automatic settle();
      repeat (6) @(negedge clk);
   endtask

   task automatic drain();
      logic [7:0] d;
      host_rd(8'h08, d);
      host_rd(8'h15, d);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      check("R11 line after reset", 8'(line_level()), 8'h01);
      host_rd(8'h04, d); check("R11 los live", d, 8'h00);
      host_rd(8'h06, d); check("R11 los mask", d, 8'h00);
      host_rd(8'h08, d); check("R11 los pend", d, 8'h00);
      host_rd(8'h13, d); check("R11 ais live", d, 8'h00);
      host_rd(8'h14, d); check("R4 ais mask reset", d, 8'h00);
      host_rd(8'h15, d); check("R11 ais pend", d, 8'h00);
   endtask

   task automatic t_mask_rw();
      logic [7:0] d;
      host_wr(8'h06, 8'hA5);
      host_wr(8'h14, 8'h3C);
      host_rd(8'h06, d); check("R2 los mask readback", d, 8'hA5);
      host_rd(8'h14, d); check("R2 ais mask readback", d, 8'h3C);
      host_wr(8'h06, 8'h00);
      host_wr(8'h14, 8'h00);
   endtask

   task automatic t_live_track();
      logic [7:0] d;
      @(negedge clk);
      los_in = 8'h81;
      ais_in = 8'h42;
      settle();
      host_rd(8'h04, d); check("R1 los live masked off", d, 8'h81);
      host_rd(8'h13, d); check("R1 ais live masked off", d, 8'h42);
      host_rd(8'h08, d); check("R4 no pend when masked", d, 8'h00);
      check("R4 line high when masked", 8'(line_level()), 8'h01);
   endtask

   task automatic t_both_edges();
      logic [7:0] d;
      host_wr(8'h06, 8'hFF);
      @(negedge clk);
      los_in[2] = 1'b1;
      settle();
      check("R6 line low on pending", 8'(line_level()), 8'h00);
      host_rd(8'h08, d); check("R3 rising edge pend", d, 8'h04);
      check("R5 line high after clear", 8'(line_level()), 8'h01);
      host_rd(8'h08, d); check("R5 pend cleared", d, 8'h00);
      @(negedge clk);
      los_in[2] = 1'b0;
      settle();
      host_rd(8'h08, d); check("R3 falling edge pend", d, 8'h04);
      drain();
   endtask

   task automatic t_group_isolation();
      logic [7:0] d;
      host_wr(8'h14, 8'hFF);
      @(negedge clk);
      los_in[0] = ~los_in[0];
      ais_in[1] = ~ais_in[1];
      settle();
      host_rd(8'h04, d);
      check("R7 los pend after live read", 8'(line_level()), 8'h00);
      host_rd(8'h08, d); check("R7 los cleared by live read", d, 8'h00);
      host_rd(8'h15, d); check("R7 ais untouched", d, 8'h02);
      check("R6 line high when all clear", 8'(line_level()), 8'h01);
   endtask

   task automatic t_mask_gate();
      logic [7:0] d;
      host_wr(8'h06, 8'h0F);
      @(negedge clk);
      los_in[7] = ~los_in[7];
      los_in[1] = ~los_in[1];
      settle();
      host_rd(8'h08, d); check("R4 only unmasked pend", d, 8'h02);
      drain();
   endtask

   task automatic t_collision();
      logic [7:0] d;
      host_wr(8'h06, 8'h01);
      drain();
      @(negedge clk);
      addr = 8'h08;
      rd_n = 1'b0;
      los_in[0] = ~los_in[0];
      @(negedge clk);
      @(negedge clk);
      rd_n = 1'b1;
      settle();
      check("R8 line low after collision", 8'(line_level()), 8'h00);
      host_rd(8'h08, d); check("R8 event kept over clear", d, 8'h01);
      host_rd(8'h08, d); check("R8 later read clears", d, 8'h00);
   endtask

   task automatic t_unmapped();
      logic [7:0] d;
      @(negedge clk);
      los_in[0] = ~los_in[0];
      settle();
      host_rd(8'h05, d); check("R10 unmapped 05", d, 8'h00);
      host_rd(8'h07, d); check("R10 unmapped 07", d, 8'h00);
      host_rd(8'h30, d); check("R10 unmapped 30", d, 8'h00);
      check("R10 unmapped keeps line low", 8'(line_level()), 8'h00);
      host_wr(8'h08, 8'h00);
      host_wr(8'h04, 8'hAA);
      host_rd(8'h08, d); check("R10 pend write ignored", d, 8'h01);
      host_rd(8'h04, d); check("R10 live write ignored", d, los_in);
      host_wr(8'h15, 8'hFF);
      host_rd(8'h15, d); check("R10 ais pend write ignored", d, 8'h00);
   endtask

   task automatic t_open_drain();
      @(negedge clk);
      los_in[0] = ~los_in[0];
      settle();
      check("R9 oe on pending", 8'(irq_oe), 8'h01);
      check("R9 drive value low", 8'(irq_n), 8'h00);
      drain();
      check("R9 oe off when idle", 8'(irq_oe), 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mask_rw();
      t_live_track();
      t_both_edges();
      t_group_isolation();
      t_mask_gate();
      t_collision();
      t_unmapped();
      t_open_drain();
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule